// File: doc/BRIEF.md
# Chained command buffer walker

This block walks a software-owned queue of fixed-size instructions. Each instruction is eight 64-bit words. Instructions sit in buffer segments that are linked together. A segment holds n instructions followed by one extra word. That extra word carries the address of the next segment.

Software writes a 64-byte aligned start pointer and a segment size in words. It then adds instruction credits as it publishes work. A consumer holds a pull request while it can take an instruction.

The walker fetches one instruction at a time by issuing eight single-word reads. It returns the assembled 512-bit instruction as a one-cycle pulse. Once the last instruction of a segment has been delivered, it reads the link word and makes that address the new read pointer. It can optionally announce that the finished segment may be released. A swap option reverses the byte order inside every 64-bit word that is read, link words included.

Top module: `cmd_chain_walker`

## Requirements
- R1: After reset no read request, instruction pulse or release pulse is active, and `next_ptr` is 0.
- R2: A segment size whose low three bits are not `001`, or which is below 9, raises `cfg_err`, and no read request is issued while it stands. Sizes of the form 8n+1 with n of at least 1 leave `cfg_err` low.
- R3: A fetch starts only when `pull_req` is high and at least one credit is available. Each credit is one instruction, added through `dbell_cnt` on a `dbell_valid` pulse. With no credit, no read request is issued.
- R4: An instruction at line P is read as eight requests, one outstanding at a time, at byte addresses P*64 + 8k for k = 0..7 in rising order. A request holds its address until `rd_req_ready` is seen.
- R5: `inst_valid` pulses for exactly one cycle after the eighth response. In `inst_data`, bits 64k+63:64k hold word k.
- R6: `next_ptr` gives the next line to fetch. It steps by one in the cycle `inst_valid` pulses.
- R7: After the n-th instruction of a segment, the walker reads the link word at byte address `next_ptr`*64. It loads link bits 48:6 into `next_ptr`, and the following instructions come from that line.
- R8: With `cfg_release` high, taking a link gives one `free_valid` pulse, with `free_addr` set to the start line of the finished segment. With `cfg_release` low, no pulse is given.
- R9: With `cfg_swap` high, byte j of every response word becomes byte 7-j, both for instruction words and for the link word.
- R10: A `load_valid` pulse while idle sets `next_ptr` to `load_ptr` and restarts the per-segment instruction count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_seg_words | input | 13 | Segment size in 64-bit words (8n+1) |
| cfg_swap | input | 1 | Byte-reverse each response word |
| cfg_release | input | 1 | Announce finished segments |
| cfg_err | output | 1 | Segment size setting is invalid |
| load_valid | input | 1 | Start pointer write strobe |
| load_ptr | input | 43 | Start line (address bits 48:6) |
| dbell_valid | input | 1 | Credit add strobe |
| dbell_cnt | input | 8 | Instructions added to the credit |
| pull_req | input | 1 | Consumer can accept an instruction |
| rd_req_valid | output | 1 | Word read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 49 | Byte address of the word |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 64 | Read data word |
| inst_valid | output | 1 | Instruction pulse |
| inst_data | output | 512 | Assembled instruction, word 0 lowest |
| free_valid | output | 1 | Segment release pulse |
| free_addr | output | 43 | Line of the released segment |
| next_ptr | output | 43 | Next line to be fetched |

## Verification
The checker assumes that software changes `cfg_seg_words`, `cfg_release` and `cfg_swap` only while the walker is idle. It also assumes that memory returns exactly one response per accepted request and never returns an unrequested one. The bench writes configuration only between scenarios, after the last instruction and link read have completed. Its memory model answers each accepted request one cycle later with a single response.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int WORD_W     = 64;
  localparam int INST_WORDS = 8;
  localparam int WSEL_W     = $clog2(INST_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INST_REQ,
    ST_INST_RSP,
    ST_LINK_REQ,
    ST_LINK_RSP
  } walk_state_e;
endpackage

// File: rtl/cbw_seg_decode.sv
module cbw_seg_decode #(
  parameter int SIZE_W = 13
) (
  input  logic [SIZE_W-1:0] seg_words,
  output logic [SIZE_W-4:0] insts_per_seg,
  output logic              cfg_bad
);
  localparam logic [SIZE_W-1:0] MIN_WORDS = SIZE_W'(9);

  always_comb begin
    insts_per_seg = seg_words[SIZE_W-1:3];
    cfg_bad       = (seg_words[2:0] != 3'b001) || (seg_words < MIN_WORDS);
  end
endmodule

// File: rtl/cbw_byteswap.sv
module cbw_byteswap #(
  parameter int WORD_W = 64
) (
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] swapped;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_byte
      assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
  endgenerate

  assign dout = en ? swapped : din;
endmodule

// File: rtl/cbw_credit.sv
module cbw_credit #(
  parameter int CRED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_valid,
  input  logic [CRED_W-1:0] add_cnt,
  input  logic              take,
  output logic              has_credit
);
  logic [CRED_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = add_valid || take;
    cnt_d  = cnt_q + (add_valid ? add_cnt : '0) - CRED_W'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign has_credit = (cnt_q != '0);
endmodule

// File: rtl/cmd_chain_walker.sv
module cmd_chain_walker
  import cbw_pkg::*;
#(
  parameter int ADDR_W   = 49,
  parameter int LINE_LSB = 6,
  parameter int SIZE_W   = 13,
  parameter int CRED_W   = 8,
  localparam int PTR_W   = ADDR_W - LINE_LSB,
  localparam int INST_W  = WORD_W * INST_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] cfg_seg_words,
  input  logic              cfg_swap,
  input  logic              cfg_release,
  output logic              cfg_err,
  input  logic              load_valid,
  input  logic [PTR_W-1:0]  load_ptr,
  input  logic              dbell_valid,
  input  logic [CRED_W-1:0] dbell_cnt,
  input  logic              pull_req,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              inst_valid,
  output logic [INST_W-1:0] inst_data,
  output logic              free_valid,
  output logic [PTR_W-1:0]  free_addr,
  output logic [PTR_W-1:0]  next_ptr
);
  localparam int IDX_W = SIZE_W - 3;

  walk_state_e state_q, state_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [INST_WORDS-1:0][WORD_W-1:0] buf_q, buf_d;
  logic              ivld_q, ivld_d, fvld_q, fvld_d;
  logic [PTR_W-1:0]  faddr_q, faddr_d;

  logic [IDX_W-1:0]  insts_per_seg;
  logic              cfg_bad, has_credit, start;
  logic [WORD_W-1:0] rsp_word;

  cbw_seg_decode #(.SIZE_W(SIZE_W)) i_decode (
    .seg_words     (cfg_seg_words),
    .insts_per_seg (insts_per_seg),
    .cfg_bad       (cfg_bad)
  );

  cbw_byteswap #(.WORD_W(WORD_W)) i_swap (
    .en   (cfg_swap),
    .din  (rd_rsp_data),
    .dout (rsp_word)
  );

  cbw_credit #(.CRED_W(CRED_W)) i_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .add_valid  (dbell_valid),
    .add_cnt    (dbell_cnt),
    .take       (start),
    .has_credit (has_credit)
  );

  assign start = (state_q == ST_IDLE) && pull_req && has_credit &&
                 !cfg_bad && !load_valid;

  always_comb begin
    state_d = state_q;
    wsel_d  = wsel_q;
    ptr_d   = ptr_q;
    base_d  = base_q;
    idx_d   = idx_q;
    buf_d   = buf_q;
    ivld_d  = 1'b0;
    fvld_d  = 1'b0;
    faddr_d = faddr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load_valid) begin
          ptr_d  = load_ptr;
          base_d = load_ptr;
          idx_d  = '0;
        end else if (start) begin
          wsel_d  = '0;
          state_d = ST_INST_REQ;
        end
      end
      ST_INST_REQ: if (rd_req_ready) state_d = ST_INST_RSP;
      ST_INST_RSP: begin
        if (rd_rsp_valid) begin
          buf_d[wsel_q] = rsp_word;
          if (wsel_q == WSEL_W'(INST_WORDS - 1)) begin
            ivld_d = 1'b1;
            ptr_d  = ptr_q + 1'b1;
            idx_d  = idx_q + 1'b1;
            state_d = (IDX_W'(idx_q + 1'b1) == insts_per_seg) ? ST_LINK_REQ : ST_IDLE;
          end else begin
            wsel_d  = wsel_q + 1'b1;
            state_d = ST_INST_REQ;
          end
        end
      end
      ST_LINK_REQ: if (rd_req_ready) state_d = ST_LINK_RSP;
      ST_LINK_RSP: begin
        if (rd_rsp_valid) begin
          ptr_d   = rsp_word[ADDR_W-1:LINE_LSB];
          base_d  = rsp_word[ADDR_W-1:LINE_LSB];
          idx_d   = '0;
          fvld_d  = cfg_release;
          faddr_d = base_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wsel_q  <= '0;
      ptr_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      buf_q   <= '0;
      ivld_q  <= 1'b0;
      fvld_q  <= 1'b0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      wsel_q  <= wsel_d;
      ptr_q   <= ptr_d;
      base_q  <= base_d;
      idx_q   <= idx_d;
      ivld_q  <= ivld_d;
      fvld_q  <= fvld_d;
      faddr_q <= faddr_d;
      if (state_q == ST_INST_RSP && rd_rsp_valid) buf_q <= buf_d;
    end
  end

  always_comb begin
    rd_req_valid = (state_q == ST_INST_REQ) || (state_q == ST_LINK_REQ);
    if (state_q == ST_INST_REQ)
      rd_req_addr = {ptr_q, LINE_LSB'({wsel_q, 3'b000})};
    else
      rd_req_addr = {ptr_q, {LINE_LSB{1'b0}}};
  end

  assign cfg_err    = cfg_bad;
  assign inst_valid = ivld_q;
  assign inst_data  = buf_q;
  assign free_valid = fvld_q;
  assign free_addr  = faddr_q;
  assign next_ptr   = ptr_q;
endmodule

// File: rtl/cbw_walker_chk.sv
module cbw_walker_chk #(
  parameter int ADDR_W = 49,
  parameter int PTR_W  = 43
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_err,
  input logic              cfg_release,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              inst_valid,
  input logic              free_valid,
  input logic [PTR_W-1:0]  next_ptr
);
  // R2
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !rd_req_valid);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R5
  inst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst_valid |=> !inst_valid);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inst_valid) |-> next_ptr == $past(next_ptr) + 1'b1);

  // R8
  free_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> cfg_release);
endmodule

bind cmd_chain_walker cbw_walker_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_walker_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_err      (cfg_err),
  .cfg_release  (cfg_release),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .inst_valid   (inst_valid),
  .free_valid   (free_valid),
  .next_ptr     (next_ptr)
);

// File: tb/test_cmd_chain_walker.sv
module test_cmd_chain_walker;
  localparam int ADDR_W = 49;
  localparam int PTR_W  = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] cfg_seg_words = 13'd17;
  logic cfg_swap = 1'b0, cfg_release = 1'b0, cfg_err;
  logic load_valid = 1'b0;
  logic [PTR_W-1:0] load_ptr = '0;
  logic dbell_valid = 1'b0;
  logic [7:0] dbell_cnt = '0;
  logic pull_req = 1'b0;
  logic rd_req_valid, rd_req_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic inst_valid, free_valid;
  logic [511:0] inst_data;
  logic [PTR_W-1:0] free_addr, next_ptr;

  assign rd_req_ready = 1'b1;

  always #10 clk = ~clk;

  cmd_chain_walker i_cmd_chain_walker (
    .clk(clk), .rst_n(rst_n), .cfg_seg_words(cfg_seg_words), .cfg_swap(cfg_swap),
    .cfg_release(cfg_release), .cfg_err(cfg_err), .load_valid(load_valid),
    .load_ptr(load_ptr), .dbell_valid(dbell_valid), .dbell_cnt(dbell_cnt),
    .pull_req(pull_req), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .inst_valid(inst_valid), .inst_data(inst_data), .free_valid(free_valid),
    .free_addr(free_addr), .next_ptr(next_ptr)
  );

  int checks = 0, failures = 0;
  int inst_cnt = 0, free_cnt = 0, log_n = 0;
  logic [511:0] last_inst = '0;
  logic [PTR_W-1:0] last_free = '0;
  logic [ADDR_W-1:0] addr_log [0:63];
  logic [63:0] mem [logic [ADDR_W-1:0]];
  bit done = 0;

  function automatic logic [63:0] pattern(input logic [ADDR_W-1:0] a);
    return {8'h5A, 7'h00, a};
  endfunction

  function automatic logic [63:0] swap64(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mem_rd(input logic [ADDR_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return pattern(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [PTR_W-1:0] p);
    @(negedge clk); load_valid = 1'b1; load_ptr = p;
    @(negedge clk); load_valid = 1'b0;
  endtask

  task automatic ring(input int n);
    @(negedge clk); dbell_valid = 1'b1; dbell_cnt = 8'(n);
    @(negedge clk); dbell_valid = 1'b0;
  endtask

  task automatic wait_insts(input int target);
    for (int i = 0; i < 500 && inst_cnt < target; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_inst(input logic [PTR_W-1:0] line, input bit sw, input string req);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] e;
      e = pattern({line, 6'(k * 8)});
      if (sw) e = swap64(e);
      chk(last_inst[64*k +: 64] === e, req, last_inst[64*k +: 64], e);
    end
  endtask

  initial begin : responder
    bit pend = 0;
    logic [63:0] pdata = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = pdata;
        pend = 0;
      end
      if (rd_req_valid) begin
        if (log_n < 64) addr_log[log_n] = rd_req_addr;
        log_n++;
        pdata = mem_rd(rd_req_addr);
        pend = 1;
      end
      if (inst_valid) begin inst_cnt++; last_inst = inst_data; end
      if (free_valid) begin free_cnt++; last_free = free_addr; end
    end
  end

  task automatic t_reset;
    chk(rd_req_valid === 1'b0, "R1 rd_req_valid", 64'(rd_req_valid), 0);
    chk(inst_valid === 1'b0, "R1 inst_valid", 64'(inst_valid), 0);
    chk(free_valid === 1'b0, "R1 free_valid", 64'(free_valid), 0);
    chk(next_ptr === '0, "R1 next_ptr", 64'(next_ptr), 0);
  endtask

  task automatic t_no_credit;
    cfg_seg_words = 13'd17; cfg_release = 1'b1; cfg_swap = 1'b0;
    load(43'h100);
    chk(next_ptr === 43'h100, "R10 load sets pointer", 64'(next_ptr), 64'h100);
    log_n = 0; pull_req = 1'b1;
    idle(20);
    chk(log_n == 0, "R3 no read without credit", 64'(log_n), 0);
  endtask

  task automatic t_fetch;
    log_n = 0;
    ring(1);
    wait_insts(1);
    chk(inst_cnt == 1, "R5 one instruction", 64'(inst_cnt), 1);
    for (int k = 0; k < 8; k++)
      chk(addr_log[k] === {43'h100, 6'(k * 8)}, "R4 word address order",
          64'(addr_log[k]), 64'({43'h100, 6'(k * 8)}));
    check_inst(43'h100, 1'b0, "R5 word placement");
    chk(next_ptr === 43'h101, "R6 pointer step", 64'(next_ptr), 64'h101);
    idle(20);
    chk(log_n == 8, "R3 stop when credit used", 64'(log_n), 8);
  endtask

  task automatic t_link;
    mem[{43'h102, 6'd0}] = 64'({43'h200, 6'd0});
    log_n = 0;
    ring(2);
    wait_insts(3);
    chk(addr_log[8] === {43'h102, 6'd0}, "R7 link read address", 64'(addr_log[8]), 64'({43'h102, 6'd0}));
    chk(addr_log[9] === {43'h200, 6'd0}, "R7 fetch from link target", 64'(addr_log[9]), 64'({43'h200, 6'd0}));
    check_inst(43'h200, 1'b0, "R7 data from new segment");
    chk(next_ptr === 43'h201, "R7 pointer after link", 64'(next_ptr), 64'h201);
    chk(free_cnt == 1, "R8 release pulse count", 64'(free_cnt), 1);
    chk(last_free === 43'h100, "R8 release address", 64'(last_free), 64'h100);
  endtask

  task automatic t_reload;
    idle(4);
    cfg_release = 1'b0;
    load(43'h500);
    ring(1);
    wait_insts(4);
    idle(4);
    load(43'h600);
    mem[{43'h602, 6'd0}] = 64'({43'h700, 6'd0});
    ring(2);
    wait_insts(6);
    idle(10);
    chk(next_ptr === 43'h700, "R10 count restarts on load", 64'(next_ptr), 64'h700);
    chk(free_cnt == 1, "R8 no release when disabled", 64'(free_cnt), 1);
  endtask

  task automatic t_swap;
    cfg_seg_words = 13'd9; cfg_swap = 1'b1;
    load(43'h300);
    mem[{43'h301, 6'd0}] = swap64(64'({43'h400, 6'd0}));
    ring(1);
    wait_insts(7);
    check_inst(43'h300, 1'b1, "R9 instruction words swapped");
    idle(10);
    chk(next_ptr === 43'h400, "R9 link swapped", 64'(next_ptr), 64'h400);
    cfg_swap = 1'b0;
  endtask

  task automatic t_cfg_err;
    pull_req = 1'b0;
    cfg_seg_words = 13'd9;
    #1 chk(cfg_err === 1'b0, "R2 size 9 accepted", 64'(cfg_err), 0);
    cfg_seg_words = 13'd25;
    #1 chk(cfg_err === 1'b0, "R2 size 25 accepted", 64'(cfg_err), 0);
    cfg_seg_words = 13'd1;
    #1 chk(cfg_err === 1'b1, "R2 size 1 rejected", 64'(cfg_err), 1);
    cfg_seg_words = 13'd16;
    #1 chk(cfg_err === 1'b1, "R2 size 16 rejected", 64'(cfg_err), 1);
    log_n = 0;
    pull_req = 1'b1;
    ring(1);
    idle(20);
    chk(log_n == 0, "R2 no read on bad size", 64'(log_n), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_no_credit();
    t_fetch();
    t_link();
    t_reload();
    t_swap();
    t_cfg_err();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule